// File: doc/BRIEF.md
# Register Write-Pending Scoreboard

The scoreboard keeps one bit for each architectural register. A 1 means that an instruction which will write that register has been issued and has not finished. Issue logic sets a bit when it hands an instruction with a destination write to a lane. The bit clears when that lane is granted the register-file write. It also clears when the lane finishes without a result and will never write. During issue, a combinational check reports whether any source operand of the incoming instruction reads a register that is still pending, so the issue logic can hold the instruction back.

Each requester lane has a small tracker state machine. The tracker records, at issue, whether the instruction intends to write. It forgets that intent once the lane stops being busy. Its states are:
- `LN_IDLE`: no intent is held.
- `LN_WRITER`: intent is held.
- `LN_SILENT`: the instruction was issued without a write.

Its transitions are:
- Issue with the write flag goes to `LN_WRITER` from any state.
- Issue without the write flag goes to `LN_SILENT` from any state.
- With no issue, a lane that is not busy goes to `LN_IDLE`.
- Otherwise the state holds.

The abandon clear is raised only in `LN_WRITER`. A parameter selects binary or one-hot register addressing.

Top module: `reg_pend_scoreboard`

## Requirements
- R1: While reset is active, and in the first cycle after it, the pending vector `pend_o` is all zero.
- R2: A pulse on `iss_lane[l]` with `iss_wr_flag`=1 sets the bit for `iss_dst` on the next clock edge.
- R3: A pulse on `iss_lane[l]` with `iss_wr_flag`=0 sets no bit.
- R4: `wr_grant[l]`=1 clears the bit addressed by lane `l`'s `lane_dst` slice on the next edge.
- R5: If one bit is both set and cleared in the same cycle, it ends up 1. Bits that are neither set nor cleared keep their value.
- R6: When a lane issued with the write flag signals `lane_done` with `res_valid`=0, its `lane_dst` bit is cleared.
- R7: The latched write intent is dropped in any cycle where `lane_busy` is 0 and no issue occurs. A later `lane_done` with `res_valid`=0 then clears nothing.
- R8: A lane whose bit in `ALWAYS_WR` is 1 never applies the abandon clear.
- R9: `hazard` is 1 only when `iss_valid`=1 and some source `s` has `src_rd_flag[s]`=1 and a pending register in its mask.
- R10: A source with `src_rd_flag[s]`=0 never raises `hazard`.
- R11: In binary mode (`ONE_HOT`=0) an address `a` selects mask `1<<a`. In one-hot mode (`ONE_HOT`=1) the address itself is the mask, and a multi-bit mask covers several registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_lane | input | NUM_LANES | Per-lane issue strobe, at most one bit set |
| iss_wr_flag | input | 1 | The issued instruction writes a register |
| iss_dst | input | AW | Destination register address |
| src_rd_flag | input | NUM_SRC | Per-source read enable |
| src_addr | input | NUM_SRC*AW | Source register addresses, source 0 in the low bits |
| lane_busy | input | NUM_LANES | Lane is executing |
| lane_dst | input | NUM_LANES*AW | Each lane's destination address, lane 0 in the low bits |
| wr_grant | input | NUM_LANES | Register-file write granted to the lane |
| lane_done | input | NUM_LANES | Lane finished its operation |
| res_valid | input | NUM_LANES | Lane's result carries a valid write |
| hazard | output | 1 | A source of the issuing instruction is pending |
| pend_o | output | NUM_REGS | Pending-write vector |

## Verification
The properties take for granted that at most one lane receives an issue strobe per cycle, because a single destination address is shared by all lanes. They also take for granted that a lane's `lane_dst` names the register it was issued for. The stimulus keeps to both rules. It issues only to a lane that is not busy, records that lane's destination, and presents the recorded destination whenever that lane is granted or finishes. Random traffic mixes same-cycle set and clear of one register, abandons with and without a valid result, and always-writing lanes, and the results are compared against a bit array kept in the bench.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        LN_IDLE   = 2'd0,
        LN_WRITER = 2'd1,
        LN_SILENT = 2'd2
    } lane_state_e;

endpackage

// File: rtl/sb_addr_to_mask.sv
module sb_addr_to_mask #(
    parameter int NUM_REGS = 32,
    parameter bit ONE_HOT  = 1'b0,
    parameter int AW       = ONE_HOT ? NUM_REGS : $clog2(NUM_REGS)
) (
    input  logic [AW-1:0]       addr,
    output logic [NUM_REGS-1:0] mask
);

    generate
        if (ONE_HOT) begin : g_direct
            // address already is the register mask
            assign mask = addr;
        end else begin : g_shift
            assign mask = NUM_REGS'(1) << addr;
        end
    endgenerate

endmodule

// File: rtl/sb_lane_tracker.sv
module sb_lane_tracker
    import sb_pkg::*;
#(
    parameter bit ALWAYS_WRITES = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic issue,
    input  logic wr_flag,
    input  logic done,
    input  logic res_valid,
    output logic abandon
);

    lane_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (issue) begin
            state_d = wr_flag ? LN_WRITER : LN_SILENT;
        end else begin
            unique case (state_q)
                LN_IDLE:   state_d = LN_IDLE;
                LN_WRITER: if (!busy) state_d = LN_IDLE;
                LN_SILENT: if (!busy) state_d = LN_IDLE;
                default:   state_d = LN_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        abandon = 1'b0;
        unique case (state_q)
            LN_WRITER: abandon = done && !res_valid && !ALWAYS_WRITES;
            LN_IDLE,
            LN_SILENT: abandon = 1'b0;
            default:   abandon = 1'b0;
        endcase
    end

endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check #(
    parameter int NUM_REGS = 32,
    parameter int NUM_SRC  = 3
) (
    input  logic [NUM_REGS-1:0]         pend,
    input  logic                        iss_valid,
    input  logic [NUM_SRC-1:0]          rd_flag,
    input  logic [NUM_SRC*NUM_REGS-1:0] src_mask,
    output logic                        hazard
);

    logic [NUM_SRC-1:0] hit;

    genvar s;
    generate
        for (s = 0; s < NUM_SRC; s++) begin : g_src
            assign hit[s] = rd_flag[s] && |(pend & src_mask[s*NUM_REGS +: NUM_REGS]);
        end
    endgenerate

    assign hazard = iss_valid && |hit;

endmodule

// File: rtl/reg_pend_scoreboard.sv
module reg_pend_scoreboard #(
    parameter int                  NUM_REGS  = 32,
    parameter int                  NUM_LANES = 4,
    parameter int                  NUM_SRC   = 3,
    parameter bit                  ONE_HOT   = 1'b0,
    parameter logic [NUM_LANES-1:0] ALWAYS_WR = '0,
    parameter int                  AW        = ONE_HOT ? NUM_REGS : $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      iss_valid,
    input  logic [NUM_LANES-1:0]      iss_lane,
    input  logic                      iss_wr_flag,
    input  logic [AW-1:0]             iss_dst,
    input  logic [NUM_SRC-1:0]        src_rd_flag,
    input  logic [NUM_SRC*AW-1:0]     src_addr,
    input  logic [NUM_LANES-1:0]      lane_busy,
    input  logic [NUM_LANES*AW-1:0]   lane_dst,
    input  logic [NUM_LANES-1:0]      wr_grant,
    input  logic [NUM_LANES-1:0]      lane_done,
    input  logic [NUM_LANES-1:0]      res_valid,
    output logic                      hazard,
    output logic [NUM_REGS-1:0]       pend_o
);

    logic [NUM_REGS-1:0]           pend_q;
    logic [NUM_REGS-1:0]           iss_mask;
    logic [NUM_LANES*NUM_REGS-1:0] lane_mask;
    logic [NUM_LANES*NUM_REGS-1:0] lane_set;
    logic [NUM_LANES*NUM_REGS-1:0] lane_clr;
    logic [NUM_SRC*NUM_REGS-1:0]   src_mask;
    logic [NUM_LANES-1:0]          abandon;
    logic [NUM_REGS-1:0]           set_all;
    logic [NUM_REGS-1:0]           clr_all;

    sb_addr_to_mask #(.NUM_REGS(NUM_REGS), .ONE_HOT(ONE_HOT), .AW(AW)) u_iss_dec (
        .addr (iss_dst),
        .mask (iss_mask)
    );

    genvar l, s;
    generate
        for (l = 0; l < NUM_LANES; l++) begin : g_lane
            sb_addr_to_mask #(.NUM_REGS(NUM_REGS), .ONE_HOT(ONE_HOT), .AW(AW)) u_dec (
                .addr (lane_dst[l*AW +: AW]),
                .mask (lane_mask[l*NUM_REGS +: NUM_REGS])
            );

            sb_lane_tracker #(.ALWAYS_WRITES(ALWAYS_WR[l])) u_trk (
                .clk       (clk),
                .rst_n     (rst_n),
                .busy      (lane_busy[l]),
                .issue     (iss_lane[l]),
                .wr_flag   (iss_wr_flag),
                .done      (lane_done[l]),
                .res_valid (res_valid[l]),
                .abandon   (abandon[l])
            );

            assign lane_set[l*NUM_REGS +: NUM_REGS] =
                (iss_lane[l] && iss_wr_flag) ? iss_mask : '0;
            assign lane_clr[l*NUM_REGS +: NUM_REGS] =
                (wr_grant[l] || abandon[l]) ? lane_mask[l*NUM_REGS +: NUM_REGS] : '0;
        end

        for (s = 0; s < NUM_SRC; s++) begin : g_srcdec
            sb_addr_to_mask #(.NUM_REGS(NUM_REGS), .ONE_HOT(ONE_HOT), .AW(AW)) u_dec (
                .addr (src_addr[s*AW +: AW]),
                .mask (src_mask[s*NUM_REGS +: NUM_REGS])
            );
        end
    endgenerate

    // merge per-lane masks
    always_comb begin
        set_all = '0;
        clr_all = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            set_all = set_all | lane_set[i*NUM_REGS +: NUM_REGS];
            clr_all = clr_all | lane_clr[i*NUM_REGS +: NUM_REGS];
        end
    end

    // set has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_all) | set_all;
        end
    end

    sb_hazard_check #(.NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC)) u_haz (
        .pend      (pend_q),
        .iss_valid (iss_valid),
        .rd_flag   (src_rd_flag),
        .src_mask  (src_mask),
        .hazard    (hazard)
    );

    assign pend_o = pend_q;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int NUM_REGS  = 32,
    parameter int NUM_LANES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 iss_valid,
    input logic [NUM_LANES-1:0] iss_lane,
    input logic                 hazard,
    input logic [NUM_REGS-1:0]  set_all,
    input logic [NUM_REGS-1:0]  clr_all,
    input logic [NUM_REGS-1:0]  pend
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> pend == '0);

    // R2
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_all) |=> (pend & $past(set_all)) == $past(set_all));

    // R4
    clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_all & ~set_all)) |=> (pend & $past(clr_all & ~set_all)) == '0);

    // R5
    hold_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend ^ $past(pend)) & ~$past(set_all | clr_all)) == '0);

    // R9
    quiet_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> !hazard);

    // R2
    single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iss_lane));

endmodule

bind reg_pend_scoreboard sb_checker #(
    .NUM_REGS  (NUM_REGS),
    .NUM_LANES (NUM_LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_lane  (iss_lane),
    .hazard    (hazard),
    .set_all   (set_all),
    .clr_all   (clr_all),
    .pend      (pend_q)
);

// File: tb/reg_pend_scoreboard_tb.sv
module reg_pend_scoreboard_tb;

    localparam int NR = 32;
    localparam int NL = 4;
    localparam int NS = 3;
    localparam int AW = 5;
    localparam logic [NL-1:0] ALW = 4'b1000;

    // row = {op[1:0], lane[1:0], reg[4:0], expected bit}
    // op 0 issue+write, 1 issue no write, 2 grant, 3 done without result
    localparam int NROW = 14;
    localparam logic [9:0] TBL [NROW] = '{
        {2'd0, 2'd0, 5'd5,  1'b1},  // R2
        {2'd1, 2'd1, 5'd9,  1'b0},  // R3
        {2'd3, 2'd1, 5'd9,  1'b0},
        {2'd2, 2'd0, 5'd5,  1'b0},  // R4
        {2'd0, 2'd2, 5'd7,  1'b1},
        {2'd3, 2'd2, 5'd7,  1'b0},  // R6
        {2'd0, 2'd3, 5'd12, 1'b1},
        {2'd3, 2'd3, 5'd12, 1'b1},  // R8
        {2'd2, 2'd3, 5'd12, 1'b0},
        {2'd0, 2'd0, 5'd31, 1'b1},  // R11 top address
        {2'd2, 2'd0, 5'd31, 1'b0},
        {2'd0, 2'd1, 5'd0,  1'b1},  // R11 address 0
        {2'd2, 2'd1, 5'd0,  1'b0},
        {2'd1, 2'd2, 5'd3,  1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid, iss_wr_flag, hazard;
    logic [NL-1:0] iss_lane, lane_busy, wr_grant, lane_done, res_valid;
    logic [AW-1:0] iss_dst;
    logic [NS-1:0] src_rd_flag;
    logic [NS*AW-1:0] src_addr;
    logic [NL*AW-1:0] lane_dst;
    logic [NR-1:0] pend_o;

    // one-hot variant
    logic oh_iss_valid, oh_iss_wr, oh_hazard;
    logic [1:0] oh_iss_lane;
    logic [7:0] oh_iss_dst, oh_pend;
    logic [1:0] oh_rd;
    logic [15:0] oh_src;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    reg_pend_scoreboard #(.NUM_REGS(NR), .NUM_LANES(NL), .NUM_SRC(NS),
                          .ONE_HOT(1'b0), .ALWAYS_WR(ALW)) u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_lane(iss_lane),
        .iss_wr_flag(iss_wr_flag), .iss_dst(iss_dst), .src_rd_flag(src_rd_flag),
        .src_addr(src_addr), .lane_busy(lane_busy), .lane_dst(lane_dst),
        .wr_grant(wr_grant), .lane_done(lane_done), .res_valid(res_valid),
        .hazard(hazard), .pend_o(pend_o)
    );

    reg_pend_scoreboard #(.NUM_REGS(8), .NUM_LANES(2), .NUM_SRC(2),
                          .ONE_HOT(1'b1), .ALWAYS_WR(2'b00)) u_dut_oh (
        .clk(clk), .rst_n(rst_n), .iss_valid(oh_iss_valid), .iss_lane(oh_iss_lane),
        .iss_wr_flag(oh_iss_wr), .iss_dst(oh_iss_dst), .src_rd_flag(oh_rd),
        .src_addr(oh_src), .lane_busy(2'b01), .lane_dst(16'h0),
        .wr_grant(2'b00), .lane_done(2'b00), .res_valid(2'b00),
        .hazard(oh_hazard), .pend_o(oh_pend)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulses_off();
        iss_valid = 0; iss_lane = '0; iss_wr_flag = 0; iss_dst = '0;
        wr_grant = '0; lane_done = '0; res_valid = '0;
        src_rd_flag = '0; src_addr = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [NR-1:0] model;
        logic [NL-1:0] lw;
        logic [AW-1:0] dst_of [NL];
        pulses_off();
        lane_busy = '0; lane_dst = '0;
        oh_iss_valid = 0; oh_iss_lane = '0; oh_iss_wr = 0; oh_iss_dst = '0;
        oh_rd = '0; oh_src = '0;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 pend in reset", pend_o, '0);
        rst_n = 1'b1;
        step();
        chk("R1 pend after reset", pend_o, '0);
        chk("R9 hazard idle", hazard, 1'b0);

        // table walk
        for (int i = 0; i < NROW; i++) begin
            logic [1:0] op;
            logic [1:0] ln;
            logic [4:0] rg;
            {op, ln, rg} = TBL[i][9:1];
            if (op <= 2'd1) begin
                iss_valid = 1; iss_lane = 4'(1) << ln; iss_wr_flag = (op == 2'd0);
                iss_dst = rg; lane_busy[ln] = 1'b1;
            end else begin
                lane_dst[ln*AW +: AW] = rg;
                if (op == 2'd2) wr_grant[ln] = 1'b1;
                else lane_done[ln] = 1'b1;
            end
            step();
            pulses_off();
            if (op >= 2'd2) lane_busy[ln] = 1'b0;
            chk($sformatf("R2/R3/R4/R6/R8/R11 row %0d", i), pend_o[rg], TBL[i][0]);
        end
        lane_busy = '0;
        step();

        // R5 same-cycle set and clear
        iss_valid = 1; iss_lane = 4'b0001; iss_wr_flag = 1; iss_dst = 5'd4; lane_busy[0] = 1;
        step(); pulses_off();
        iss_valid = 1; iss_lane = 4'b0010; iss_wr_flag = 1; iss_dst = 5'd4; lane_busy[1] = 1;
        lane_dst[0 +: AW] = 5'd4; wr_grant[0] = 1;
        step(); pulses_off(); lane_busy[0] = 0;
        chk("R5 set wins over clear", pend_o[4], 1'b1);

        // R9 / R10 hazard with r4 pending
        iss_valid = 1; src_rd_flag = 3'b010; src_addr = {5'd0, 5'd4, 5'd1};
        #1 chk("R9 hazard on pending source", hazard, 1'b1);
        src_rd_flag = 3'b101;
        #1 chk("R10 unread source ignored", hazard, 1'b0);
        src_rd_flag = 3'b010; iss_valid = 0;
        #1 chk("R9 no hazard without issue", hazard, 1'b0);
        pulses_off();
        lane_dst[AW +: AW] = 5'd4; wr_grant[1] = 1;
        step(); pulses_off(); lane_busy[1] = 0;
        chk("R4 grant clears r4", pend_o[4], 1'b0);

        // R7 intent dropped while not busy
        iss_valid = 1; iss_lane = 4'b0100; iss_wr_flag = 1; iss_dst = 5'd6; lane_busy[2] = 1;
        step(); pulses_off();
        lane_busy[2] = 0;
        step();
        lane_busy[2] = 1; lane_dst[2*AW +: AW] = 5'd6; lane_done[2] = 1;
        step(); pulses_off(); lane_busy[2] = 0;
        chk("R7 no abandon after intent dropped", pend_o[6], 1'b1);
        wr_grant[2] = 1;
        step(); pulses_off();
        chk("R4 late grant clears r6", pend_o[6], 1'b0);

        // R11 one-hot variant
        oh_iss_valid = 1; oh_iss_lane = 2'b01; oh_iss_wr = 1; oh_iss_dst = 8'h20;
        step();
        oh_iss_valid = 0; oh_iss_lane = '0; oh_iss_wr = 0;
        chk("R11 one-hot direct mask", oh_pend, 8'h20);
        oh_iss_valid = 1; oh_rd = 2'b01; oh_src = {8'h00, 8'h21};
        #1 chk("R11 one-hot multi-bit source hits", oh_hazard, 1'b1);
        oh_src = {8'h00, 8'h01};
        #1 chk("R11 one-hot source misses", oh_hazard, 1'b0);
        oh_iss_valid = 0; oh_rd = '0;

        // random traffic against a bit array
        model = pend_o; lw = '0;
        for (int c = 0; c < 400; c++) begin
            logic [NR-1:0] setm, clrm;
            logic [NL-1:0] fin;
            logic exp_h;
            int free;
            setm = '0; clrm = '0; fin = '0;
            pulses_off();
            free = -1;
            if ($urandom % 2 == 0) begin
                int off;
                off = $urandom % NL;
                for (int k = 0; k < NL; k++)
                    if (free < 0 && !lane_busy[(off + k) % NL]) free = (off + k) % NL;
            end
            for (int l = 0; l < NL; l++) begin
                if (lane_busy[l] && ($urandom % 4 == 0)) begin
                    fin[l] = 1'b1;
                    lane_dst[l*AW +: AW] = dst_of[l];
                    if (lw[l] && ($urandom % 2 == 0)) begin
                        wr_grant[l] = 1; clrm[dst_of[l]] = 1'b1;
                    end else begin
                        lane_done[l] = 1; res_valid[l] = 1'($urandom % 2);
                        if (lw[l] && !res_valid[l] && !ALW[l]) clrm[dst_of[l]] = 1'b1;
                    end
                end
            end
            if (free >= 0) begin
                iss_valid = 1; iss_lane = 4'(1) << free; iss_wr_flag = 1'($urandom % 2);
                iss_dst = 5'($urandom); dst_of[free] = iss_dst; lane_busy[free] = 1'b1;
                if (iss_wr_flag) setm[iss_dst] = 1'b1;
            end else begin
                iss_valid = 1'($urandom % 2);
            end
            src_rd_flag = 3'($urandom); src_addr = 15'($urandom);
            exp_h = 1'b0;
            for (int s = 0; s < NS; s++)
                if (src_rd_flag[s] && model[src_addr[s*AW +: AW]]) exp_h = 1'b1;
            exp_h = exp_h && iss_valid;
            #1 chk("R9 random hazard", hazard, exp_h);
            for (int l = 0; l < NL; l++) begin
                if (free == l) lw[l] = iss_wr_flag;
                else if (!lane_busy[l]) lw[l] = 1'b0;
            end
            model = (model & ~clrm) | setm;
            step();
            lane_busy = lane_busy & ~fin;
            chk("R5 random pending vector", pend_o, model);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule